// File: doc/BRIEF.md
# Watermark Write-Drain Request Scheduler

This block holds the pending memory requests of one channel and decides which one each bank serves next. Every bank owns two age-ordered queues, one for reads and one for writes. A single channel-wide mode bit decides which direction is served. While the bit is clear only read queues are looked at. While it is set only write queues are looked at, even if the other direction has work waiting.

The mode bit is controlled by hysteresis on the total number of writes held across all banks. The block enters write mode once that total climbs to the upper level. It goes back to read mode once the total has drained to the lower level. Between the two levels it keeps its current mode, so writes are drained in long bursts and the bus turns around rarely.

A bank controller drives a combinational query: a bank number, whether that bank has a row open, and which row is open. The answer is the chosen entry and its queue position. When the bank has a row open, the oldest entry that hits that row wins; otherwise the oldest entry wins. The answer also carries two lookahead flags, which a page policy uses to decide whether to keep the row open. Once the controller has issued the column command, it removes the entry by bank, direction and position. Command timing is handled elsewhere.

Top module: `wds_scheduler`

## Requirements
- R1: After a synchronous active-high reset the block is in read mode (`wr_mode` = 0) and every queue is empty, so `sel_valid` is 0 for every bank.
- R2: An enqueue is appended as the youngest entry of the queue selected by `enq_bank` and `enq_write` (1 = write). `enq_ok` is high in the same cycle exactly when `enq_valid` is high and that queue holds fewer than DEPTH entries. When the queue is full the request is dropped and no queue changes, even if an entry of that same queue is removed in the same cycle.
- R3: When the total count of held writes, after the cycle's store and removal, is at or above HIGH_WM, `wr_mode` is 1 from the next cycle on.
- R4: When that total is at or below LOW_WM, `wr_mode` is 0 from the next cycle on.
- R5: When the total lies strictly between LOW_WM and HIGH_WM, `wr_mode` keeps its value.
- R6: In read mode the answer uses only the queried bank's read queue. If `q_active` is 1 and some read's row equals `q_open_row`, the oldest such read is chosen. Otherwise the oldest read is chosen. `sel_valid` is 0 when the read queue is empty, even if writes are pending. `sel_slot` is the queue position, with 0 being the oldest, and `sel_write` equals the mode.
- R7: In write mode the same rule applies to the bank's write queue only, and reads are never returned.
- R8: `sel_more` is 1 exactly when the current mode's queue of the queried bank holds two or more entries.
- R9: `sel_more_hits` is 1 exactly when at least two entries in the current mode's queue of the queried bank have a row equal to `q_open_row`, whatever the value of `q_active`.
- R10: A removal deletes the entry at `rm_slot` of the queue selected by `rm_bank` and `rm_write`, and every younger entry moves up one position in age order. A removal whose `rm_slot` is not below that queue's occupancy has no effect.
- R11: A write store and a write removal in the same cycle leave the total write count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Store a new request this cycle |
| enq_write | input | 1 | Direction of the new request, 1 = write |
| enq_bank | input | BANK_W | Target bank of the new request |
| enq_row | input | ROW_W | Row of the new request |
| enq_tag | input | TAG_W | Caller's handle for the new request |
| enq_ok | output | 1 | The new request is accepted this cycle |
| q_bank | input | BANK_W | Bank being queried |
| q_active | input | 1 | Queried bank has a row open |
| q_open_row | input | ROW_W | Row open in the queried bank |
| sel_valid | output | 1 | A request is offered for the queried bank |
| sel_write | output | 1 | Direction of the offered request |
| sel_slot | output | SLOT_W | Queue position of the offered request |
| sel_row | output | ROW_W | Row of the offered request |
| sel_tag | output | TAG_W | Handle of the offered request |
| sel_more | output | 1 | Two or more entries in the current mode's queue |
| sel_more_hits | output | 1 | Two or more entries in that queue hit `q_open_row` |
| rm_valid | input | 1 | Remove an entry this cycle |
| rm_write | input | 1 | Direction of the queue to remove from |
| rm_bank | input | BANK_W | Bank of the queue to remove from |
| rm_slot | input | SLOT_W | Queue position to remove |
| wr_mode | output | 1 | 1 = write mode, 0 = read mode |

## Verification
The hardest state to reach is the one where a mode is held: the write total sits strictly between the two levels, and it got there from above in one run and from below in another. Only then does the hysteresis show, and a wrong mode there is invisible unless the request direction that is pending is the one being starved. The stimulus uses a small configuration with levels 2 and 5 and only eight write slots. Directed sequences fill the write queues past the upper level and then drain them one removal at a time. A long pseudo-random mix of stores and removals, with rows drawn from a four-value set so that row hits and double hits are common, crosses both levels in both directions many times. After every cycle the queried answer for every bank, open-row state and row is compared with a bench model.

// File: rtl/wds_pkg.sv
`timescale 1ns/1ps
package wds_pkg;

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;

    localparam int unsigned NUM_DIRS = 2;

    // Hysteresis rule for the service direction.
    function automatic logic hyst_mode(input logic cur, input int lvl,
                                       input int lo, input int hi);
        if (lvl >= hi)
            return 1'b1;
        if (lvl <= lo)
            return 1'b0;
        return cur;
    endfunction

    // Width of a field indexing n items, never below one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wds_bank_queue.sv
`timescale 1ns/1ps
module wds_bank_queue #(
    parameter int DEPTH  = 4,
    parameter int ROW_W  = 14,
    parameter int TAG_W  = 8,
    parameter int SLOT_W = wds_pkg::idx_width(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_req,
    input  logic [ROW_W-1:0]  push_row,
    input  logic [TAG_W-1:0]  push_tag,
    input  logic              pop_req,
    input  logic [SLOT_W-1:0] pop_slot,
    input  logic              match_act,
    input  logic [ROW_W-1:0]  match_row,
    output logic              full,
    output logic              push_done,
    output logic              pop_done,
    output logic              pick_valid,
    output logic [SLOT_W-1:0] pick_slot,
    output logic [ROW_W-1:0]  pick_row,
    output logic [TAG_W-1:0]  pick_tag,
    output logic              more_than_one,
    output logic              hits_two
);

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [TAG_W-1:0] tag;
    } entry_t;

    entry_t            slot_q [DEPTH];
    logic [CNT_W-1:0]  used_q;
    logic [CNT_W-1:0]  tail_idx;
    entry_t            new_ent;

    assign full      = (int'(used_q) == DEPTH);
    assign push_done = push_req && !full;
    assign pop_done  = pop_req && (int'(pop_slot) < int'(used_q));
    assign tail_idx  = used_q - CNT_W'(pop_done);
    assign new_ent   = '{row: push_row, tag: push_tag};

    // Age-ordered storage: position 0 is the oldest entry.
    always_ff @(posedge clk) begin
        if (rst) begin
            used_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (pop_done && i >= int'(pop_slot))
                    slot_q[i] <= slot_q[i+1];
            end
            for (int i = 0; i < DEPTH; i++) begin
                if (push_done && int'(tail_idx) == i)
                    slot_q[i] <= new_ent;
            end
            used_q <= used_q + CNT_W'(push_done) - CNT_W'(pop_done);
        end
    end

    // Row-hit search over the occupied positions.
    logic              hit_seen;
    logic [SLOT_W-1:0] hit_pos;
    logic [CNT_W-1:0]  hit_cnt;

    always_comb begin
        hit_seen = 1'b0;
        hit_pos  = '0;
        hit_cnt  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(used_q) && slot_q[i].row == match_row) begin
                if (!hit_seen) begin
                    hit_seen = 1'b1;
                    hit_pos  = SLOT_W'(i);
                end
                hit_cnt = hit_cnt + CNT_W'(1);
            end
        end
    end

    assign pick_valid    = (used_q != '0);
    assign pick_slot     = (match_act && hit_seen) ? hit_pos : '0;
    assign pick_row      = slot_q[pick_slot].row;
    assign pick_tag      = slot_q[pick_slot].tag;
    assign more_than_one = (int'(used_q) >= 2);
    assign hits_two      = (int'(hit_cnt) >= 2);

endmodule

// File: rtl/wds_level_tracker.sv
`timescale 1ns/1ps
module wds_level_tracker #(
    parameter int TOTAL   = 32,
    parameter int LOW_WM  = 8,
    parameter int HIGH_WM = 16,
    parameter int LVL_W   = $clog2(TOTAL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [LVL_W-1:0] level,
    output logic             wr_mode
);

    logic [LVL_W-1:0] level_nxt;
    logic             mode_nxt;

    always_comb begin
        level_nxt = level;
        if (inc && !dec)
            level_nxt = level + LVL_W'(1);
        else if (dec && !inc)
            level_nxt = level - LVL_W'(1);
    end

    assign mode_nxt = wds_pkg::hyst_mode(wr_mode, int'(level_nxt), LOW_WM, HIGH_WM);

    always_ff @(posedge clk) begin
        if (rst) begin
            level   <= '0;
            wr_mode <= wds_pkg::DIR_READ;
        end else begin
            level   <= level_nxt;
            wr_mode <= mode_nxt;
        end
    end

endmodule

// File: rtl/wds_scheduler.sv
`timescale 1ns/1ps
module wds_scheduler #(
    parameter int NUM_BANKS = 8,
    parameter int DEPTH     = 4,
    parameter int ROW_W     = 14,
    parameter int TAG_W     = 8,
    parameter int LOW_WM    = 8,
    parameter int HIGH_WM   = 16,
    parameter int BANK_W    = wds_pkg::idx_width(NUM_BANKS),
    parameter int SLOT_W    = wds_pkg::idx_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enq_valid,
    input  logic              enq_write,
    input  logic [BANK_W-1:0] enq_bank,
    input  logic [ROW_W-1:0]  enq_row,
    input  logic [TAG_W-1:0]  enq_tag,
    output logic              enq_ok,
    input  logic [BANK_W-1:0] q_bank,
    input  logic              q_active,
    input  logic [ROW_W-1:0]  q_open_row,
    output logic              sel_valid,
    output logic              sel_write,
    output logic [SLOT_W-1:0] sel_slot,
    output logic [ROW_W-1:0]  sel_row,
    output logic [TAG_W-1:0]  sel_tag,
    output logic              sel_more,
    output logic              sel_more_hits,
    input  logic              rm_valid,
    input  logic              rm_write,
    input  logic [BANK_W-1:0] rm_bank,
    input  logic [SLOT_W-1:0] rm_slot,
    output logic              wr_mode
);

    localparam int TOTAL = NUM_BANKS * DEPTH;
    localparam int LVL_W = $clog2(TOTAL + 1);
    localparam int ND    = wds_pkg::NUM_DIRS;

    if (LOW_WM >= HIGH_WM || HIGH_WM > TOTAL) begin : g_bad_levels
        $error("wds_scheduler: watermarks need LOW_WM < HIGH_WM <= NUM_BANKS*DEPTH");
    end

    logic              q_full     [ND][NUM_BANKS];
    logic              q_pushed   [ND][NUM_BANKS];
    logic              q_popped   [ND][NUM_BANKS];
    logic              pk_valid   [ND][NUM_BANKS];
    logic [SLOT_W-1:0] pk_slot    [ND][NUM_BANKS];
    logic [ROW_W-1:0]  pk_row     [ND][NUM_BANKS];
    logic [TAG_W-1:0]  pk_tag     [ND][NUM_BANKS];
    logic              pk_more    [ND][NUM_BANKS];
    logic              pk_hits2   [ND][NUM_BANKS];

    for (genvar d = 0; d < ND; d++) begin : g_dir
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic push_here;
            logic pop_here;
            assign push_here = enq_valid && (int'(enq_write) == d) && (int'(enq_bank) == b);
            assign pop_here  = rm_valid && (int'(rm_write) == d) && (int'(rm_bank) == b);

            wds_bank_queue #(
                .DEPTH (DEPTH),
                .ROW_W (ROW_W),
                .TAG_W (TAG_W),
                .SLOT_W(SLOT_W)
            ) u_q (
                .clk          (clk),
                .rst          (rst),
                .push_req     (push_here),
                .push_row     (enq_row),
                .push_tag     (enq_tag),
                .pop_req      (pop_here),
                .pop_slot     (rm_slot),
                .match_act    (q_active),
                .match_row    (q_open_row),
                .full         (q_full[d][b]),
                .push_done    (q_pushed[d][b]),
                .pop_done     (q_popped[d][b]),
                .pick_valid   (pk_valid[d][b]),
                .pick_slot    (pk_slot[d][b]),
                .pick_row     (pk_row[d][b]),
                .pick_tag     (pk_tag[d][b]),
                .more_than_one(pk_more[d][b]),
                .hits_two     (pk_hits2[d][b])
            );
        end
    end

    // Write occupancy change this cycle.
    logic wr_inc;
    logic wr_dec;

    always_comb begin
        wr_inc = 1'b0;
        wr_dec = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            wr_inc = wr_inc | q_pushed[wds_pkg::DIR_WRITE][b];
            wr_dec = wr_dec | q_popped[wds_pkg::DIR_WRITE][b];
        end
    end

    logic [LVL_W-1:0] wr_level;

    wds_level_tracker #(
        .TOTAL  (TOTAL),
        .LOW_WM (LOW_WM),
        .HIGH_WM(HIGH_WM),
        .LVL_W  (LVL_W)
    ) u_trk (
        .clk    (clk),
        .rst    (rst),
        .inc    (wr_inc),
        .dec    (wr_dec),
        .level  (wr_level),
        .wr_mode(wr_mode)
    );

    assign enq_ok = enq_valid && !q_full[enq_write][enq_bank];

    // Answer comes only from the queue of the current direction.
    assign sel_write     = wr_mode;
    assign sel_valid     = pk_valid[wr_mode][q_bank];
    assign sel_slot      = pk_slot[wr_mode][q_bank];
    assign sel_row       = pk_row[wr_mode][q_bank];
    assign sel_tag       = pk_tag[wr_mode][q_bank];
    assign sel_more      = pk_more[wr_mode][q_bank];
    assign sel_more_hits = pk_hits2[wr_mode][q_bank];

endmodule

// File: rtl/wds_scheduler_chk.sv
`timescale 1ns/1ps
module wds_scheduler_chk #(
    parameter int LOW_WM  = 8,
    parameter int HIGH_WM = 16,
    parameter int LVL_W   = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_mode,
    input logic [LVL_W-1:0] level
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst)
            past_ok <= 1'b0;
        else
            past_ok <= 1'b1;
    end

    a_r1_reset_read: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !wr_mode);

    a_r3_high_writes: assert property (@(posedge clk) disable iff (rst)
        int'(level) >= HIGH_WM |-> wr_mode);

    a_r4_low_reads: assert property (@(posedge clk) disable iff (rst)
        int'(level) <= LOW_WM |-> !wr_mode);

    a_r5_hold_between: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$stable(wr_mode)) |-> (int'(level) >= HIGH_WM || int'(level) <= LOW_WM));

    a_r11_level_step: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (int'(level) == int'($past(level)) ||
                     int'(level) == int'($past(level)) + 1 ||
                     int'(level) + 1 == int'($past(level))));

endmodule

bind wds_scheduler wds_scheduler_chk #(
    .LOW_WM (LOW_WM),
    .HIGH_WM(HIGH_WM),
    .LVL_W  (LVL_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_mode(wr_mode),
    .level  (wr_level)
);

// File: tb/sim_wds_scheduler.sv
`timescale 1ns/1ps
module sim_wds_scheduler;

    localparam int NB = 2;
    localparam int DP = 4;
    localparam int RW = 3;
    localparam int TW = 8;
    localparam int LO = 2;
    localparam int HI = 5;
    localparam int BW = 1;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enq_valid = 1'b0, enq_write = 1'b0;
    logic [BW-1:0] enq_bank = '0;
    logic [RW-1:0] enq_row = '0;
    logic [TW-1:0] enq_tag = '0;
    logic          enq_ok;
    logic [BW-1:0] q_bank = '0;
    logic          q_active = 1'b0;
    logic [RW-1:0] q_open_row = '0;
    logic          sel_valid, sel_write, sel_more, sel_more_hits;
    logic [SW-1:0] sel_slot;
    logic [RW-1:0] sel_row;
    logic [TW-1:0] sel_tag;
    logic          rm_valid = 1'b0, rm_write = 1'b0;
    logic [BW-1:0] rm_bank = '0;
    logic [SW-1:0] rm_slot = '0;
    logic          wr_mode;

    always #2.5 clk = ~clk;

    wds_scheduler #(
        .NUM_BANKS(NB), .DEPTH(DP), .ROW_W(RW), .TAG_W(TW),
        .LOW_WM(LO), .HIGH_WM(HI)
    ) u0 (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_write(enq_write), .enq_bank(enq_bank),
        .enq_row(enq_row), .enq_tag(enq_tag), .enq_ok(enq_ok),
        .q_bank(q_bank), .q_active(q_active), .q_open_row(q_open_row),
        .sel_valid(sel_valid), .sel_write(sel_write), .sel_slot(sel_slot),
        .sel_row(sel_row), .sel_tag(sel_tag), .sel_more(sel_more),
        .sel_more_hits(sel_more_hits),
        .rm_valid(rm_valid), .rm_write(rm_write), .rm_bank(rm_bank),
        .rm_slot(rm_slot), .wr_mode(wr_mode)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench model.
    int m_cnt [2][NB];
    int m_row [2][NB][DP];
    int m_tag [2][NB][DP];
    int m_lvl = 0;
    bit m_mode = 1'b0;
    int next_tag = 1;
    int unsigned lfsr = 32'h1234_5678;

    function automatic int unsigned rnd();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    task automatic check_bit(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // One clock of enqueue and/or remove, then update the model.
    task automatic cycle(bit ev, bit ew, int eb, int er, bit rv, bit rw, int rb, int rs);
        bit exp_ok;
        int d;
        @(negedge clk);
        enq_valid = ev; enq_write = ew; enq_bank = BW'(eb); enq_row = RW'(er);
        enq_tag = TW'(next_tag);
        rm_valid = rv; rm_write = rw; rm_bank = BW'(rb); rm_slot = SW'(rs);
        #1;
        exp_ok = ev && (m_cnt[ew][eb] < DP);
        check_bit("R2", "enq_ok", enq_ok, exp_ok);
        @(posedge clk);
        #1;
        enq_valid = 1'b0; rm_valid = 1'b0;
        if (rv && rs < m_cnt[rw][rb]) begin
            for (int i = rs; i < m_cnt[rw][rb] - 1; i++) begin
                m_row[rw][rb][i] = m_row[rw][rb][i+1];
                m_tag[rw][rb][i] = m_tag[rw][rb][i+1];
            end
            m_cnt[rw][rb]--;
            if (rw) m_lvl--;
        end
        if (exp_ok) begin
            d = m_cnt[ew][eb];
            m_row[ew][eb][d] = er;
            m_tag[ew][eb][d] = next_tag % 256;
            m_cnt[ew][eb]++;
            if (ew) m_lvl++;
            next_tag++;
        end
        if (m_lvl >= HI) m_mode = 1'b1;
        else if (m_lvl <= LO) m_mode = 1'b0;
    endtask

    // Compare the query answer for every bank / open state / row.
    task automatic check_all(string tagmsg);
        check_bit("R3 R4 R5", {tagmsg, " wr_mode"}, wr_mode, m_mode);
        for (int b = 0; b < NB; b++) begin
            for (int act = 0; act < 2; act++) begin
                for (int r = 0; r < 4; r++) begin
                    int d, n, slot, hits, first;
                    bit ev, ok;
                    if (act == 0 && r > 1) continue;
                    q_bank = BW'(b); q_active = act[0]; q_open_row = RW'(r);
                    #1;
                    d = m_mode; n = m_cnt[d][b];
                    ev = (n > 0); hits = 0; first = -1;
                    for (int i = 0; i < n; i++) begin
                        if (m_row[d][b][i] == r) begin
                            hits++;
                            if (first < 0) first = i;
                        end
                    end
                    slot = (act == 1 && first >= 0) ? first : 0;
                    ok = (sel_valid === ev) && (sel_write === m_mode) &&
                         (sel_more === (n >= 2)) && (sel_more_hits === (hits >= 2));
                    if (ev)
                        ok = ok && (int'(sel_slot) == slot) &&
                             (int'(sel_row) == m_row[d][b][slot]) &&
                             (int'(sel_tag) == m_tag[d][b][slot]);
                    n_chk++;
                    if (!ok) begin
                        n_bad++;
                        $display("FAIL %s %s bank=%0d act=%0d row=%0d actual v=%0b w=%0b s=%0d t=%0d m=%0b h=%0b expected v=%0b w=%0b s=%0d t=%0d m=%0b h=%0b",
                                 m_mode ? "R7 R8 R9" : "R6 R8 R9", tagmsg, b, act, r,
                                 sel_valid, sel_write, sel_slot, sel_tag, sel_more, sel_more_hits,
                                 ev, m_mode, slot, ev ? m_tag[d][b][slot] : 0, n >= 2, hits >= 2);
                    end
                end
            end
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state
        check_bit("R1", "wr_mode after reset", wr_mode, 1'b0);
        check_all("R1 reset");

        // Reads on bank 0, writes on both banks up to HI-1.
        cycle(1, 0, 0, 1, 0, 0, 0, 0);
        cycle(1, 0, 0, 2, 0, 0, 0, 0);
        cycle(1, 0, 0, 2, 0, 0, 0, 0);
        cycle(1, 1, 1, 3, 0, 0, 0, 0);
        cycle(1, 1, 1, 3, 0, 0, 0, 0);
        cycle(1, 1, 0, 1, 0, 0, 0, 0);
        cycle(1, 1, 1, 0, 0, 0, 0, 0);
        check_bit("R5", "read mode at level 4", wr_mode, 1'b0);
        check_all("R6 reads only, bank1 read-empty");

        // R11: write store plus write removal at level 4.
        cycle(1, 1, 0, 2, 1, 1, 1, 0);
        check_bit("R11", "mode after balanced store/remove", wr_mode, 1'b0);
        cycle(1, 1, 0, 3, 0, 0, 0, 0);
        check_bit("R3", "write mode at level 5", wr_mode, 1'b1);
        check_all("R7 write mode, reads pending");

        // R10: removal beyond occupancy is ignored.
        cycle(0, 0, 0, 0, 1, 1, 1, 3);
        check_all("R10 stale slot");

        // Drain: R5 hold, then R4.
        cycle(0, 0, 0, 0, 1, 1, 0, 1);
        check_bit("R5", "write mode held at 4", wr_mode, 1'b1);
        cycle(0, 0, 0, 0, 1, 1, 0, 0);
        check_bit("R5", "write mode held at 3", wr_mode, 1'b1);
        cycle(0, 0, 0, 0, 1, 1, 1, 0);
        check_bit("R4", "read mode at level 2", wr_mode, 1'b0);
        check_all("R4 drained");

        // R2: full queue drops, even with same-queue removal.
        cycle(1, 0, 1, 1, 0, 0, 0, 0);
        cycle(1, 0, 1, 1, 0, 0, 0, 0);
        cycle(1, 0, 1, 2, 0, 0, 0, 0);
        cycle(1, 0, 1, 1, 0, 0, 0, 0);
        cycle(1, 0, 1, 3, 0, 0, 0, 0);
        cycle(1, 0, 1, 3, 1, 0, 1, 2);
        check_all("R2 full drop");

        // Pseudo-random sweep.
        for (int s = 0; s < 2500; s++) begin
            int unsigned r;
            bit rw;
            r = rnd();
            rw = r[6] ? m_mode : r[7];
            cycle(r[0] | r[1], r[2], int'(r[3]), int'(r[9:8]),
                  r[4] | r[5], rw, int'(r[10]), int'(r[12:11]));
            check_all("sweep R10 R11");
        end

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog all requirements actual=hung expected=complete");
            finish_run();
        end
    end

endmodule